// File: doc/BRIEF.md
# Keyboard Serial-Line to ASCII Decoder

This block sits on the two open-collector lines of a PC-style keyboard (clock and data) and turns the stream of key scan codes into ASCII characters. The keyboard clock is brought into the system clock domain, cleaned of short glitches, and its falling edges are used to shift in 11-bit frames. Every frame is checked. A frame with a bad parity bit raises a one-cycle parity error. A frame with a bad start bit or a bad stop bit raises a one-cycle framing error. In both cases the byte is discarded.

Accepted bytes go to a translator. It follows the release prefix and the extended-key prefix, keeps track of the shift and caps-lock states, and looks up letters, digits, space and enter. Each printable key press gives one-cycle `char_vld_o` together with the 7-bit character. A partial frame that stalls is abandoned after an idle timeout, so the next frame is received correctly.

Top module: `kbd_ascii_decoder`

## Requirements
- R1: A frame is a 0 start bit, eight data bits sent least significant bit first, a parity bit and a 1 stop bit. Each bit is sampled on a filtered falling edge of the keyboard clock. A valid frame whose byte maps to a character gives exactly one `char_vld_o` pulse.
- R2: The parity bit must make the count of ones over the data bits and the parity bit odd. If it does not, `parity_err_o` pulses for one cycle and no character comes out.
- R3: A start bit of 1 or a stop bit of 0 makes `frame_err_o` pulse for one cycle, and no character comes out.
- R4: The byte F0 marks a release. The code that follows F0 gives no character.
- R5: Each repeated make code of a held key gives another character.
- R6: The prefix E0 marks an extended key. An extended make code gives no character. The sequence E0 F0 xx is a release, and it leaves the next plain make code decoded normally.
- R7: Code 12 sets shift and F0 12 clears it. With shift set, letters come out in upper case (for example 1C gives 0x41 'A' instead of 0x61 'a') and digit keys give their shifted symbol (for example 1E gives 0x40 '@' instead of 0x32 '2').
- R8: Code 58 toggles caps lock. A repeated 58 sent without an F0 58 in between does not toggle it again. Caps lock makes letters upper case, but shift and caps lock together give lower case. Digits are not affected by caps lock.
- R9: A low pulse on the keyboard clock shorter than `FILT_LEN` system clocks is ignored.
- R10: When a frame is partly received and no falling edge arrives for `TIMEOUT_CYC` cycles, the bit count is cleared, so the next full frame decodes correctly.
- R11: Code 29 gives 0x20 (space) and code 5A gives 0x0D (enter), with or without shift. A code outside the table gives no character.
- R12: While reset is asserted and just after it, `char_vld_o`, `parity_err_o` and `frame_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kb_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| kb_dat_i | input | 1 | Keyboard data line (asynchronous) |
| char_vld_o | output | 1 | One-cycle strobe, a character is present |
| char_o | output | 7 | ASCII character, valid while `char_vld_o` is high |
| parity_err_o | output | 1 | One-cycle pulse for a frame with bad parity |
| frame_err_o | output | 1 | One-cycle pulse for a frame with a bad start or stop bit |

## Verification
The bench drives key sequences that trap common decoding mistakes.

- Key releases and extended prefixes are checked because a translator that lost either prefix would print the released key a second time or print the arrow's code.
- Caps lock is pressed with an auto-repeat pair. A decoder without the repeat guard would toggle twice and leave the case unchanged.
- Shift and caps lock are held together to show that the case rules combine by exclusive-or and not by OR.
- A short glitch and a stalled partial frame are injected. A receiver without the filter or the timeout would misalign every later frame, which shows up as framing errors or wrong characters.

// File: rtl/kbd_pkg.sv
package kbd_pkg;

  localparam logic [7:0] SC_EXT_PFX = 8'hE0;
  localparam logic [7:0] SC_REL_PFX = 8'hF0;
  localparam logic [7:0] SC_SHIFT   = 8'h12;
  localparam logic [7:0] SC_CAPS    = 8'h58;

  typedef struct packed {
    logic       hit;     // code is in the table
    logic       letter;  // case follows shift xor caps
    logic [6:0] plain;   // unshifted character
    logic [6:0] alt;     // shifted character
  } key_map_t;

  function automatic key_map_t key_entry(input logic is_letter, input logic [7:0] p,
                                         input logic [7:0] a);
    key_map_t e;
    e.hit    = 1'b1;
    e.letter = is_letter;
    e.plain  = p[6:0];
    e.alt    = a[6:0];
    return e;
  endfunction

  function automatic key_map_t letter_entry(input logic [7:0] lower);
    return key_entry(1'b1, lower, lower - 8'd32);
  endfunction

  function automatic key_map_t kbd_lookup(input logic [7:0] sc);
    key_map_t e;
    e = '0;
    case (sc)
      8'h1C: e = letter_entry("a");  8'h32: e = letter_entry("b");
      8'h21: e = letter_entry("c");  8'h23: e = letter_entry("d");
      8'h24: e = letter_entry("e");  8'h2B: e = letter_entry("f");
      8'h34: e = letter_entry("g");  8'h33: e = letter_entry("h");
      8'h43: e = letter_entry("i");  8'h3B: e = letter_entry("j");
      8'h42: e = letter_entry("k");  8'h4B: e = letter_entry("l");
      8'h3A: e = letter_entry("m");  8'h31: e = letter_entry("n");
      8'h44: e = letter_entry("o");  8'h4D: e = letter_entry("p");
      8'h15: e = letter_entry("q");  8'h2D: e = letter_entry("r");
      8'h1B: e = letter_entry("s");  8'h2C: e = letter_entry("t");
      8'h3C: e = letter_entry("u");  8'h2A: e = letter_entry("v");
      8'h1D: e = letter_entry("w");  8'h22: e = letter_entry("x");
      8'h35: e = letter_entry("y");  8'h1A: e = letter_entry("z");
      8'h16: e = key_entry(1'b0, "1", "!");
      8'h1E: e = key_entry(1'b0, "2", "@");
      8'h26: e = key_entry(1'b0, "3", "#");
      8'h25: e = key_entry(1'b0, "4", "$");
      8'h2E: e = key_entry(1'b0, "5", "%");
      8'h36: e = key_entry(1'b0, "6", "^");
      8'h3D: e = key_entry(1'b0, "7", "&");
      8'h3E: e = key_entry(1'b0, "8", "*");
      8'h46: e = key_entry(1'b0, "9", "(");
      8'h45: e = key_entry(1'b0, "0", ")");
      8'h29: e = key_entry(1'b0, 8'h20, 8'h20);
      8'h5A: e = key_entry(1'b0, 8'h0D, 8'h0D);
      default: e = '0;
    endcase
    return e;
  endfunction

endpackage

// File: rtl/kbd_line_filter.sv
module kbd_line_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kb_clk_i,
  input  logic kb_dat_i,
  output logic fall_o,
  output logic dat_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    clk_sync_q, dat_sync_q;
  logic          level_q, level_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          fall_q, fall_d;

  always_comb begin
    level_d = level_q;
    cnt_d   = '0;
    fall_d  = 1'b0;
    if (clk_sync_q[1] != level_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        level_d = clk_sync_q[1];
        fall_d  = level_q;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync_q <= 2'b11;
      dat_sync_q <= 2'b11;
      level_q    <= 1'b1;
      cnt_q      <= '0;
      fall_q     <= 1'b0;
    end else begin
      clk_sync_q <= {clk_sync_q[0], kb_clk_i};
      dat_sync_q <= {dat_sync_q[0], kb_dat_i};
      level_q    <= level_d;
      cnt_q      <= cnt_d;
      fall_q     <= fall_d;
    end
  end

  assign fall_o = fall_q;
  assign dat_o  = dat_sync_q[1];

  // R9: an accepted edge is always followed by a quiet cycle
  p_edge_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |=> !fall_q);
  // R9: a falling edge is only reported after the filtered level was high
  p_fall_from_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_q |-> !level_q && $past(level_q));

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fall_i,
  input  logic       dat_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       par_err_o,
  output logic       frm_err_o
);
  localparam int BITS = 11;
  localparam int BW   = $clog2(BITS + 1);
  localparam int IW   = $clog2(TIMEOUT_CYC + 1);

  logic [BW-1:0]   cnt_q, cnt_d;
  logic [BITS-2:0] sh_q, sh_d;
  logic [IW-1:0]   idle_q, idle_d;
  logic            vld_d, perr_d, ferr_d;
  logic [7:0]      byte_q, byte_d;
  logic            vld_q, perr_q, ferr_q;
  logic            start_ok, par_ok;

  assign start_ok = ~sh_q[0];
  assign par_ok   = ^sh_q[BITS-2:1];

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    idle_d = idle_q;
    vld_d  = 1'b0;
    perr_d = 1'b0;
    ferr_d = 1'b0;
    byte_d = byte_q;
    if (fall_i) begin
      idle_d = '0;
      if (cnt_q == BW'(BITS - 1)) begin
        cnt_d = '0;
        if (!start_ok || !dat_i) begin
          ferr_d = 1'b1;
        end else if (!par_ok) begin
          perr_d = 1'b1;
        end else begin
          vld_d  = 1'b1;
          byte_d = sh_q[8:1];
        end
      end else begin
        sh_d  = {dat_i, sh_q[BITS-2:1]};
        cnt_d = cnt_q + BW'(1);
      end
    end else if (cnt_q != '0) begin
      if (idle_q == IW'(TIMEOUT_CYC - 1)) begin
        cnt_d  = '0;
        idle_d = '0;
      end else begin
        idle_d = idle_q + IW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      idle_q <= '0;
      vld_q  <= 1'b0;
      perr_q <= 1'b0;
      ferr_q <= 1'b0;
      byte_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      idle_q <= idle_d;
      vld_q  <= vld_d;
      perr_q <= perr_d;
      ferr_q <= ferr_d;
      byte_q <= byte_d;
    end
  end

  assign byte_vld_o = vld_q;
  assign byte_o     = byte_q;
  assign par_err_o  = perr_q;
  assign frm_err_o  = ferr_q;

  // R1: the bit counter never passes the last bit of a frame
  p_bitcnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= BW'(BITS - 1));
  // R1: a frame result is produced only on a sampled edge
  p_result_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q || perr_q || ferr_q) |-> $past(fall_i));
  // R10: an expired idle window clears a partial frame
  p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !fall_i && idle_q == IW'(TIMEOUT_CYC - 1)) |=> cnt_q == '0);

endmodule

// File: rtl/kbd_code_xlat.sv
module kbd_code_xlat
  import kbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  output logic       char_vld_o,
  output logic [6:0] char_o
);
  logic rel_q, rel_d;
  logic ext_q, ext_d;
  logic shift_q, shift_d;
  logic caps_q, caps_d;
  logic caps_held_q, caps_held_d;
  logic       vld_q, vld_d;
  logic [6:0] chr_q, chr_d;
  key_map_t   ent;

  assign ent = kbd_lookup(byte_i);

  always_comb begin
    rel_d       = rel_q;
    ext_d       = ext_q;
    shift_d     = shift_q;
    caps_d      = caps_q;
    caps_held_d = caps_held_q;
    vld_d       = 1'b0;
    chr_d       = chr_q;
    if (byte_vld_i) begin
      if (byte_i == SC_EXT_PFX) begin
        ext_d = 1'b1;
      end else if (byte_i == SC_REL_PFX) begin
        rel_d = 1'b1;
      end else begin
        rel_d = 1'b0;
        ext_d = 1'b0;
        if (rel_q) begin
          if (!ext_q && byte_i == SC_SHIFT) shift_d     = 1'b0;
          if (!ext_q && byte_i == SC_CAPS)  caps_held_d = 1'b0;
        end else if (!ext_q) begin
          if (byte_i == SC_SHIFT) begin
            shift_d = 1'b1;
          end else if (byte_i == SC_CAPS) begin
            caps_held_d = 1'b1;
            if (!caps_held_q) caps_d = ~caps_q;
          end else if (ent.hit) begin
            vld_d = 1'b1;
            if (ent.letter) chr_d = (shift_q ^ caps_q) ? ent.alt : ent.plain;
            else            chr_d = shift_q ? ent.alt : ent.plain;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q       <= 1'b0;
      ext_q       <= 1'b0;
      shift_q     <= 1'b0;
      caps_q      <= 1'b0;
      caps_held_q <= 1'b0;
      vld_q       <= 1'b0;
      chr_q       <= '0;
    end else begin
      rel_q       <= rel_d;
      ext_q       <= ext_d;
      shift_q     <= shift_d;
      caps_q      <= caps_d;
      caps_held_q <= caps_held_d;
      vld_q       <= vld_d;
      chr_q       <= chr_d;
    end
  end

  assign char_vld_o = vld_q;
  assign char_o     = chr_q;

  // R4: no character for the code that completes a release
  p_no_char_on_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !$past(rel_q));
  // R6: no character for an extended code
  p_no_char_extended_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !$past(ext_q));
  // R8: an upper-case letter needs exactly one of shift and caps lock
  p_upper_case_rule_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && chr_q >= 7'h41 && chr_q <= 7'h5A) |-> ($past(shift_q) ^ $past(caps_q)));
  // R8: caps lock changes only while the key is not already held
  p_caps_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (caps_q != $past(caps_q)) |-> !$past(caps_held_q));

endmodule

// File: rtl/kbd_ascii_decoder.sv
module kbd_ascii_decoder #(
  parameter int FILT_LEN    = 8,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kb_clk_i,
  input  logic       kb_dat_i,
  output logic       char_vld_o,
  output logic [6:0] char_o,
  output logic       parity_err_o,
  output logic       frame_err_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       fall, dat;
  logic       byte_vld;
  logic [7:0] byte_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  kbd_line_filter #(.FILT_LEN(FILT_LEN)) u_filter (
    .clk(clk), .rst_n(rst_int_n), .kb_clk_i(kb_clk_i), .kb_dat_i(kb_dat_i),
    .fall_o(fall), .dat_o(dat)
  );

  kbd_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk(clk), .rst_n(rst_int_n), .fall_i(fall), .dat_i(dat),
    .byte_vld_o(byte_vld), .byte_o(byte_val),
    .par_err_o(parity_err_o), .frm_err_o(frame_err_o)
  );

  kbd_code_xlat u_xlat (
    .clk(clk), .rst_n(rst_int_n), .byte_vld_i(byte_vld), .byte_i(byte_val),
    .char_vld_o(char_vld_o), .char_o(char_o)
  );

  // R1: a character always follows an accepted byte
  p_char_after_byte_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    char_vld_o |-> $past(byte_vld));
  // R2: a parity error never comes with a character or a framing error
  p_err_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    parity_err_o |-> !frame_err_o && !byte_vld);
  // R12: outputs are quiet while internal reset is held
  p_quiet_in_reset_r12: assert property (@(posedge clk)
    !rst_int_n |-> !char_vld_o && !parity_err_o && !frame_err_o);

endmodule

// File: tb/test_kbd_ascii_decoder.sv
module test_kbd_ascii_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int FILT       = 8;
  localparam int TMO        = 400;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       kb_clk = 1'b1;
  logic       kb_dat = 1'b1;
  logic       char_vld;
  logic [6:0] char_val;
  logic       parity_err, frame_err;

  int checks = 0, fails = 0;
  int nchar = 0, pcnt = 0, fcnt = 0;
  logic [6:0] log_mem [0:127];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbd_ascii_decoder #(.FILT_LEN(FILT), .TIMEOUT_CYC(TMO)) i_kbd_ascii_decoder (
    .clk(clk), .rst_n(rst_n), .kb_clk_i(kb_clk), .kb_dat_i(kb_dat),
    .char_vld_o(char_vld), .char_o(char_val),
    .parity_err_o(parity_err), .frame_err_o(frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (char_vld) begin
        if (nchar < 128) log_mem[nchar] = char_val;
        nchar = nchar + 1;
      end
      if (parity_err) pcnt = pcnt + 1;
      if (frame_err)  fcnt = fcnt + 1;
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_char(input string tag, input int idx, input logic [6:0] exp);
    check_eq(tag, (idx < nchar && idx < 128) ? int'(log_mem[idx]) : -1, int'(exp));
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); kb_dat = b;
    repeat (10) @(negedge clk);
    kb_clk = 1'b0;
    repeat (20) @(negedge clk);
    kb_clk = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input bit bad_par = 0,
                            input bit bad_start = 0, input bit bad_stop = 0);
    send_bit(bad_start);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit((~^b) ^ bad_par);
    send_bit(~bad_stop);
    kb_dat = 1'b1;
    repeat (30) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (5) @(negedge clk);
    check_eq("R12 char_vld in reset", char_vld, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_eq("R12 char_vld after reset", char_vld, 0);
    check_eq("R12 errors after reset", parity_err | frame_err, 0);
  endtask

  task automatic t_plain_repeat_release;
    int b = nchar;
    send_frame(8'h1C); send_frame(8'h1C); send_frame(8'h1C);
    send_frame(8'hF0); send_frame(8'h1C);
    check_eq("R5 repeat count", nchar - b, 3);
    check_char("R1 plain letter", b, 7'h61);
    check_char("R5 repeated letter", b + 2, 7'h61);
    check_eq("R4 release silent", nchar - b, 3);
  endtask

  task automatic t_shift;
    int b = nchar;
    send_frame(8'h12); send_frame(8'h1C); send_frame(8'h1E);
    send_frame(8'hF0); send_frame(8'h1E);
    send_frame(8'hF0); send_frame(8'h12);
    send_frame(8'h1C); send_frame(8'h1E);
    check_eq("R7 shift count", nchar - b, 4);
    check_char("R7 shifted letter", b, 7'h41);
    check_char("R7 shifted digit", b + 1, 7'h40);
    check_char("R7 released letter", b + 2, 7'h61);
    check_char("R7 released digit", b + 3, 7'h32);
  endtask

  task automatic t_caps;
    int b = nchar;
    send_frame(8'h58); send_frame(8'hF0); send_frame(8'h58);
    send_frame(8'h1C);                              // A
    send_frame(8'h16);                              // 1
    send_frame(8'h12); send_frame(8'h1C);           // a (both)
    send_frame(8'hF0); send_frame(8'h12);
    send_frame(8'h58); send_frame(8'h58);           // auto-repeat: one toggle
    send_frame(8'hF0); send_frame(8'h58);
    send_frame(8'h1C);                              // a
    check_eq("R8 caps count", nchar - b, 4);
    check_char("R8 caps letter", b, 7'h41);
    check_char("R8 caps digit", b + 1, 7'h31);
    check_char("R8 shift with caps", b + 2, 7'h61);
    check_char("R8 repeat toggles once", b + 3, 7'h61);
  endtask

  task automatic t_extended;
    int b = nchar;
    send_frame(8'hE0); send_frame(8'h75);
    send_frame(8'hE0); send_frame(8'hF0); send_frame(8'h75);
    send_frame(8'hE0); send_frame(8'h1C);
    send_frame(8'hE0); send_frame(8'hF0); send_frame(8'h1C);
    check_eq("R6 extended silent", nchar - b, 0);
    send_frame(8'h1C);
    check_eq("R6 after extended count", nchar - b, 1);
    check_char("R6 after extended", b, 7'h61);
  endtask

  task automatic t_special;
    int b = nchar;
    send_frame(8'h29); send_frame(8'h5A); send_frame(8'h05);
    send_frame(8'h12); send_frame(8'h29);
    send_frame(8'hF0); send_frame(8'h12);
    check_eq("R11 special count", nchar - b, 3);
    check_char("R11 space", b, 7'h20);
    check_char("R11 enter", b + 1, 7'h0D);
    check_char("R11 shifted space", b + 2, 7'h20);
  endtask

  task automatic t_parity;
    int b = nchar, p = pcnt;
    send_frame(8'h1C, 1);
    check_eq("R2 parity error pulse", pcnt - p, 1);
    check_eq("R2 no char on bad parity", nchar - b, 0);
    send_frame(8'h32);
    check_char("R2 recovery", b, 7'h62);
  endtask

  task automatic t_framing;
    int b = nchar, f = fcnt;
    send_frame(8'h1C, 0, 0, 1);
    send_frame(8'h1C, 0, 1, 0);
    check_eq("R3 framing error pulses", fcnt - f, 2);
    check_eq("R3 no char on bad frame", nchar - b, 0);
    send_frame(8'h21);
    check_char("R3 recovery", b, 7'h63);
  endtask

  task automatic t_glitch;
    int b = nchar, f = fcnt;
    @(negedge clk); kb_clk = 1'b0;
    repeat (FILT / 2) @(negedge clk);
    kb_clk = 1'b1;
    repeat (50) @(negedge clk);
    send_frame(8'h23);
    check_eq("R9 glitch no error", fcnt - f, 0);
    check_char("R9 frame after glitch", b, 7'h64);
  endtask

  task automatic t_timeout;
    int b = nchar, f = fcnt;
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    kb_dat = 1'b1;
    repeat (TMO + 200) @(negedge clk);
    send_frame(8'h24);
    check_eq("R10 no error after stall", fcnt - f, 0);
    check_eq("R10 count after stall", nchar - b, 1);
    check_char("R10 frame after stall", b, 7'h65);
  endtask

  initial begin
    t_reset();
    t_plain_repeat_release();
    t_shift();
    t_caps();
    t_extended();
    t_special();
    t_parity();
    t_framing();
    t_glitch();
    t_timeout();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule